// File: doc/BRIEF.md
# Gray-code Sobol stochastic bitstream encoder

This block turns a 16-bit threshold into a stochastic bitstream. The random source is a one-dimensional Sobol low-discrepancy sequence. Every step of the sequence flips exactly one bit of a 16-bit running value. The bit to flip is picked from the lowest set bit of an index counter, so no matrix product is needed. Each sample is compared with the threshold, which gives one stream bit. The stream bits are packed least significant bit first into 64-bit words.

A user loads a seed, a threshold and a stream length, then pulses the start strobe. The block produces one sample per clock. Each word is offered on a valid/ready output. The final word carries a last flag. While a word waits for acceptance, generation stalls and no sample is lost. The stream ends once the word holding the final bit has been accepted. The block then waits for the next start.

Top module: `sobol_bitstream_enc`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `validOut` and `lastOut` are 0.
- R2: A start loads the running value x with `seedIn` and sets the index counter to 1. Step k (k = 1, 2, ...) first computes c, the position of the lowest 1-bit of k (bit 0 is the least significant bit). It then sets x to x XOR 2^(15-c). The sample for stream bit k-1 is the value of x after step k.
- R3: A stream bit is 1 exactly when its sample is strictly less than `threshIn`, read as an unsigned number. A threshold of 0 therefore gives an all-zero stream.
- R4: Stream bit j is placed in word floor(j/64), at bit position j mod 64. Bit position 0 is the least significant bit of `wordOut`.
- R5: In the final word, every bit position at or above the stream length mod 64 is 0, unless the stream length is a multiple of 64. `lastOut` is 1 only alongside the final word.
- R6: A stream of length N yields exactly ceil(N/64) words. After the final word is accepted, `validOut` drops in the next cycle.
- R7: While `validOut` is 1 and `readyIn` is 0, the next cycle still has `validOut` at 1, with `wordOut` and `lastOut` unchanged.
- R8: A start strobe has no effect while a stream is in progress. A start with `lenIn` equal to 0 is also ignored and produces no word.
- R9: The seed is applied for each stream. A seed of 0 gives the reference sequence that begins 0x8000, 0xC000, 0x4000, 0x6000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| startIn | input | 1 | One-cycle request to begin a stream |
| seedIn | input | 16 | Initial running value, captured at start |
| threshIn | input | 16 | Comparison threshold, captured at start |
| lenIn | input | 16 | Stream length in bits, captured at start (0 means no stream) |
| wordOut | output | 64 | Packed stream word, LSB first |
| validOut | output | 1 | `wordOut` holds a complete word |
| readyIn | input | 1 | Consumer accepts the word when high with `validOut` |
| lastOut | output | 1 | The word on offer is the final one of the stream |

## Verification
The hardest case to reach from the ports is a direction-number choice for a high lowest-set-bit position. Position 15 needs the index to reach 32768, so only a very long stream gets there. The stimulus therefore includes one maximum-length stream of 65535 bits with the consumer always ready. That run covers every direction number, including the index wrap at the end of the stream. Shorter streams run under a stuttering ready pattern. They cover word stalls, partial final words, and start strobes that arrive mid-stream.

// File: rtl/sobol_enc_pkg.sv
package sobol_enc_pkg;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RUN  = 2'd1,
    S_HOLD = 2'd2
  } encState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // capture seed/threshold, restart index, clear word
    logic step;   // advance the sequence one sample, write one bit
    logic clr;    // word accepted: clear the packing register
  } dpCmd_t;

endpackage

// File: rtl/sobol_enc_ctrl.sv
module sobol_enc_ctrl
  import sobol_enc_pkg::*;
#(
  parameter int LEN_W  = 16,
  parameter int WORD_W = 64,
  localparam int POS_W = $clog2(WORD_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startIn,
  input  logic [LEN_W-1:0] lenIn,
  input  logic             readyIn,
  output dpCmd_t           cmd,
  output logic [POS_W-1:0] bitPos,
  output logic             validOut,
  output logic             lastOut
);

  encState_t        state;
  logic [LEN_W-1:0] remBits;
  logic [POS_W-1:0] posR;
  logic             lastR;
  logic             wordDone;

  assign wordDone = (posR == POS_W'(WORD_W - 1)) || (remBits == LEN_W'(1));

  always_comb begin
    cmd.load = (state == S_IDLE) && startIn && (lenIn != '0);
    cmd.step = (state == S_RUN);
    cmd.clr  = (state == S_HOLD) && readyIn;
  end

  assign bitPos   = posR;
  assign validOut = (state == S_HOLD);
  assign lastOut  = (state == S_HOLD) && lastR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      remBits <= '0;
      posR    <= '0;
      lastR   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (cmd.load) begin
            remBits <= lenIn;
            posR    <= '0;
            lastR   <= 1'b0;
            state   <= S_RUN;
          end
        end
        S_RUN: begin
          remBits <= remBits - LEN_W'(1);
          posR    <= posR + POS_W'(1);
          if (wordDone) begin
            lastR <= (remBits == LEN_W'(1));
            state <= S_HOLD;
          end
        end
        S_HOLD: begin
          if (readyIn) begin
            posR  <= '0;
            state <= lastR ? S_IDLE : S_RUN;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R1: nothing on offer during reset
  always_comb begin
    if (!rstN) begin
      p_reset_quiet_r1: assert (!validOut && !lastOut);
    end
  end

  // R8: zero-length start leaves the block idle
  p_len_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && startIn && lenIn == '0) |=> (state == S_IDLE));

  // R8: start during a stream does not restart the length count
  p_busy_start_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RUN && !wordDone && startIn) |=> (remBits == $past(remBits) - LEN_W'(1)));

  // R6: accepting the final word ends the stream
  p_end_after_last_r6: assert property (@(posedge clk) disable iff (!rstN)
    (lastOut && readyIn) |=> !validOut);

endmodule

// File: rtl/sobol_enc_dp.sv
module sobol_enc_dp
  import sobol_enc_pkg::*;
#(
  parameter int RES_W  = 16,
  parameter int WORD_W = 64,
  localparam int POS_W = $clog2(WORD_W),
  localparam int TZ_W  = $clog2(RES_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic [POS_W-1:0]  bitPos,
  input  logic [RES_W-1:0]  seedIn,
  input  logic [RES_W-1:0]  threshIn,
  output logic [WORD_W-1:0] wordOut
);

  logic [RES_W-1:0]  xVal;
  logic [RES_W-1:0]  idx;
  logic [RES_W-1:0]  thr;
  logic [WORD_W-1:0] packReg;
  logic [TZ_W-1:0]   lowPos;
  logic [RES_W-1:0]  dirNum;
  logic [RES_W-1:0]  xNext;
  logic              sBit;

  // priority encoder: lowest set bit of the index wins
  always_comb begin
    lowPos = '0;
    for (int i = RES_W - 1; i >= 0; i--) begin
      if (idx[i]) lowPos = TZ_W'(i);
    end
  end

  // direction number for position c is 2^(RES_W-1-c)
  assign dirNum = {1'b1, {(RES_W-1){1'b0}}} >> lowPos;
  assign xNext  = xVal ^ dirNum;
  assign sBit   = (xNext < thr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xVal    <= '0;
      idx     <= RES_W'(1);
      thr     <= '0;
      packReg <= '0;
    end else if (cmd.load) begin
      xVal    <= seedIn;
      idx     <= RES_W'(1);
      thr     <= threshIn;
      packReg <= '0;
    end else if (cmd.step) begin
      xVal            <= xNext;
      idx             <= idx + RES_W'(1);
      packReg[bitPos] <= sBit;
    end else if (cmd.clr) begin
      packReg <= '0;
    end
  end

  assign wordOut = packReg;

  // R2: each sample flips exactly one bit of the running value
  p_one_flip_r2: assert property (@(posedge clk) disable iff (!rstN)
    cmd.step |=> ($countones(xVal ^ $past(xVal)) == 1));

  // R2: index advances by one per sample
  p_index_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    cmd.step |=> (idx == RES_W'($past(idx) + RES_W'(1))));

  // R9: start loads the seed into the running value
  p_seed_load_r9: assert property (@(posedge clk) disable iff (!rstN)
    cmd.load |=> (xVal == $past(seedIn)));

endmodule

// File: rtl/sobol_bitstream_enc.sv
module sobol_bitstream_enc
  import sobol_enc_pkg::*;
#(
  parameter int RES_W  = 16,
  parameter int WORD_W = 64,
  localparam int POS_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startIn,
  input  logic [RES_W-1:0]  seedIn,
  input  logic [RES_W-1:0]  threshIn,
  input  logic [RES_W-1:0]  lenIn,
  output logic [WORD_W-1:0] wordOut,
  output logic              validOut,
  input  logic              readyIn,
  output logic              lastOut
);

  dpCmd_t           cmd;
  logic [POS_W-1:0] bitPos;

  sobol_enc_ctrl #(.LEN_W(RES_W), .WORD_W(WORD_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startIn  (startIn),
    .lenIn    (lenIn),
    .readyIn  (readyIn),
    .cmd      (cmd),
    .bitPos   (bitPos),
    .validOut (validOut),
    .lastOut  (lastOut)
  );

  sobol_enc_dp #(.RES_W(RES_W), .WORD_W(WORD_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .bitPos   (bitPos),
    .seedIn   (seedIn),
    .threshIn (threshIn),
    .wordOut  (wordOut)
  );

  // R7: a stalled word stays on offer unchanged
  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (validOut && !readyIn) |=> (validOut && $stable(wordOut) && $stable(lastOut)));

endmodule

// File: tb/sobol_bitstream_enc_tb.sv
module sobol_bitstream_enc_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startIn = 1'b0;
  logic [15:0] seedIn = '0;
  logic [15:0] threshIn = '0;
  logic [15:0] lenIn = '0;
  logic [63:0] wordOut;
  logic        validOut;
  logic        readyIn = 1'b1;
  logic        lastOut;

  int checkCnt = 0;
  int failCnt  = 0;
  int wordsSeen = 0;
  int readyMode = 0;
  int cycCnt = 0;
  bit summaryDone = 0;

  logic [63:0] expWordQ[$];
  bit          expLastQ[$];

  always #2.5 clk = ~clk;

  sobol_bitstream_enc u_dut (
    .clk(clk), .rstN(rstN), .startIn(startIn), .seedIn(seedIn),
    .threshIn(threshIn), .lenIn(lenIn), .wordOut(wordOut),
    .validOut(validOut), .readyIn(readyIn), .lastOut(lastOut)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!summaryDone) begin
      summaryDone = 1;
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    end
    $finish;
  endtask

  // ready pattern driver
  initial begin
    forever begin
      @(negedge clk);
      cycCnt++;
      readyIn = (readyMode == 0) ? 1'b1 : ((cycCnt % 3) != 0 && (cycCnt % 7) != 2);
    end
  end

  // monitor: compare accepted words against the scoreboard; track stalls
  initial begin
    bit prevStall = 0;
    logic [63:0] prevWord = '0;
    bit prevLast = 0;
    forever begin
      @(negedge clk);
      #1;
      if (rstN) begin
        if (prevStall) begin
          // R7
          chk(validOut && wordOut == prevWord && lastOut == prevLast, "R7 stalled word held", wordOut, prevWord);
        end
        prevStall = validOut && !readyIn;
        prevWord  = wordOut;
        prevLast  = lastOut;
        if (validOut && readyIn) begin
          wordsSeen++;
          if (expWordQ.size() == 0) begin
            chk(0, "R8 unexpected word", wordOut, 64'h0);
          end else begin
            logic [63:0] ew;
            bit el;
            ew = expWordQ.pop_front();
            el = expLastQ.pop_front();
            // R2 R3 R4 R5: word content, packing, zero fill
            chk(wordOut == ew, "R4 word content", wordOut, ew);
            // R5: last flag
            chk(lastOut == el, "R5 last flag", {63'h0, lastOut}, {63'h0, el});
          end
        end
      end else begin
        prevStall = 0;
      end
    end
  end

  // driver: queue expectations from the requirement equations, then start
  task automatic runStream(input logic [15:0] seed, input logic [15:0] thr, input int len, input bit pushExp);
    logic [15:0] x;
    logic [63:0] w;
    x = seed;
    w = '0;
    if (pushExp) begin
      for (int k = 0; k < len; k++) begin
        logic [15:0] idx;
        int c;
        idx = 16'(k + 1);
        c = 0;
        while (!idx[c]) c++;
        x = x ^ (16'h8000 >> c);
        w[k % 64] = (x < thr);
        if ((k % 64) == 63 || k == len - 1) begin
          expWordQ.push_back(w);
          expLastQ.push_back(k == len - 1);
          w = '0;
        end
      end
    end
    @(negedge clk);
    seedIn = seed;
    threshIn = thr;
    lenIn = 16'(len);
    startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
  endtask

  task automatic drainAndCount(input int startWords, input int len, input string tag);
    int guard;
    int expN;
    guard = 0;
    while (expWordQ.size() != 0 && guard < 100000) begin
      @(negedge clk);
      guard++;
    end
    repeat (4) @(negedge clk);
    expN = (len + 63) / 64;
    chk(wordsSeen - startWords == expN, tag, 64'(wordsSeen - startWords), 64'(expN));
    // R6: stream ended, nothing on offer
    chk(!validOut, "R6 idle after last", {63'h0, validOut}, 64'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checkCnt++;
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int w0;
    #1;
    // R1: reset state
    chk(!validOut && !lastOut, "R1 outputs low in reset", {62'h0, validOut, lastOut}, 64'h0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!validOut && !lastOut, "R1 outputs low after reset", {62'h0, validOut, lastOut}, 64'h0);

    // R9 R2 R3: seed 0, threshold at half; one full word
    w0 = wordsSeen;
    runStream(16'h0000, 16'h8000, 64, 1);
    drainAndCount(w0, 64, "R6 word count 64");

    // R9: explicit reference prefix; thresh 0xC001 makes bits 1,1?: samples 8000,C000,4000,6000
    w0 = wordsSeen;
    runStream(16'h0000, 16'hC001, 4, 1);
    drainAndCount(w0, 4, "R6 word count 4");

    // R3: threshold 0 gives zeros, two words
    w0 = wordsSeen;
    runStream(16'h5A5A, 16'h0000, 100, 1);
    drainAndCount(w0, 100, "R6 word count 100");

    // R7 R5 R9: backpressure, partial final word, non-zero seed
    readyMode = 1;
    w0 = wordsSeen;
    runStream(16'h1234, 16'hFFFF, 130, 1);
    drainAndCount(w0, 130, "R6 word count 130");

    w0 = wordsSeen;
    runStream(16'hBEEF, 16'h5555, 200, 1);
    drainAndCount(w0, 200, "R6 word count 200");

    // R5: single-bit stream, sample 0x8000 below 0x9000
    w0 = wordsSeen;
    runStream(16'h0000, 16'h9000, 1, 1);
    drainAndCount(w0, 1, "R6 word count 1");

    // R8: start during a stream is ignored
    w0 = wordsSeen;
    runStream(16'h0007, 16'h4000, 300, 1);
    repeat (20) @(negedge clk);
    runStream(16'h0063, 16'hFFFF, 50, 0);
    drainAndCount(w0, 300, "R8 busy start ignored");
    readyMode = 0;

    // R8: zero length start is ignored
    w0 = wordsSeen;
    runStream(16'h0001, 16'hFFFF, 0, 0);
    repeat (100) @(negedge clk);
    chk(wordsSeen == w0 && !validOut, "R8 zero length ignored", 64'(wordsSeen - w0), 64'h0);

    // R2: maximum length reaches every direction number
    w0 = wordsSeen;
    runStream(16'h0000, 16'h3000, 65535, 1);
    drainAndCount(w0, 65535, "R6 word count 65535");

    finishRun();
  end

endmodule